// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

This block performs the data operation of a small accumulator-style processor. Each cycle it takes an operation code, an accumulator operand `a_i`, a second operand `b_i` and the current condition-code bits. It returns an 8-bit result, a flag telling the register file whether to write that result back, and the new condition-code bits N, Z, V, H and C. Operand fetch, addressing, memory cycles and instruction decode belong to the surrounding core.

The arithmetic itself is combinational. All outputs are captured in registers, so the result of the operation presented in one cycle appears on the outputs after the next rising clock edge. Each operation has its own flag rules. Any flag an operation does not define is copied from `flags_i`.

Top module: `acc_alu`

## Requirements
- R1: While `rst` is high at a rising edge, `res_o`, `wr_o` and `flags_o` are all cleared to zero.
- R2: Outputs are registered. The values seen after a rising edge are those computed from the inputs present at that edge. The flag vector is laid out as bit 4 V, bit 3 H, bit 2 N, bit 1 Z, bit 0 C.
- R3: Operation codes ADD=0 and ADC=1 (ADC adds the incoming C) form a 9-bit sum s. The outcome is C=s[8], H=bit 4 of (a^b^s), V=bit 7 of (a^b^s^(s>>1)), and the result is written.
- R4: Operation codes SUB=2, SBC=3 (SBC also subtracts the incoming C) and CMP=4 use the 9-bit difference with the same C and V rules as R3 and keep H. CMP does not write: `wr_o`=0 and `res_o` equals `a_i`.
- R5: Operation codes AND=5, OR=6, XOR=7, BIT=8 (a AND b) and PASS=9 (result is `b_i`) clear V and keep C and H. BIT does not write and returns `a_i`.
- R6: Operation codes ASR=10, LSR=11, LSL=12, ROL=13 and ROR=14 set C to the bit moved out: bit 0 for right moves, bit 7 for left moves. They then set V to the new N xor the new C.
- R7: ASR keeps bit 7, LSR and LSL shift in 0, and ROL and ROR shift the old C into the vacated end.
- R8: Operation codes INC=15 and DEC=16 add or subtract 1. V is set only when the result is 0x80 for INC or 0x7F for DEC. C and H are kept.
- R9: Operation code COM=17 inverts the operand, sets C and clears V. NEG=18 produces the two's-complement negation, with V = (a==0x80) and C = (a!=0).
- R10: Operation code CLR=19 writes 0, clears N and V, sets Z and keeps C and H.
- R11: Operation code SWAP=20 exchanges the two nibbles of `a_i`, writes the result and leaves every flag equal to `flags_i`.
- R12: Codes 21 to 31 deassert `wr_o`, return `a_i` and copy `flags_i` unchanged.
- R13: For every code 0 to 19, N is bit 7 of the computed value and Z is set when that value is zero. This includes CMP and BIT, whose value is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Operation code |
| a_i | input | 8 | Accumulator operand |
| b_i | input | 8 | Second operand |
| flags_i | input | 5 | Incoming condition bits {V,H,N,Z,C} |
| res_o | output | 8 | Registered result |
| wr_o | output | 1 | Registered result write-enable |
| flags_o | output | 5 | Registered updated condition bits |

## Verification
For compare and bit test, suppressing the write-back and updating the flags happen in the same cycle. A wrong design could drop the flag update along with the write, or write the result along with the flags. Both cases are provoked with operands whose value is zero, negative or borrowing, and the bench checks `wr_o`, the returned `a_i` and all five flags against its own model in that one output cycle. In a rotate, the incoming carry feeds the result bit while the outgoing bit replaces C in the same cycle. Random carry-in values are mixed with directed 0x01/0x80 patterns to show that the old C lands in the result and the new C leaves the flag.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int DW = 8;
  localparam int FW = 5;

  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_N = 2;
  localparam int FL_H = 3;
  localparam int FL_V = 4;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
    OP_CMP  = 5'd4,  OP_AND  = 5'd5,  OP_OR   = 5'd6,  OP_XOR  = 5'd7,
    OP_BIT  = 5'd8,  OP_PASS = 5'd9,  OP_ASR  = 5'd10, OP_LSR  = 5'd11,
    OP_LSL  = 5'd12, OP_ROL  = 5'd13, OP_ROR  = 5'd14, OP_INC  = 5'd15,
    OP_DEC  = 5'd16, OP_COM  = 5'd17, OP_NEG  = 5'd18, OP_CLR  = 5'd19,
    OP_SWAP = 5'd20
  } alu_op_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         c,
  output logic         h,
  output logic         v
);
  localparam int HB = W / 2;
  logic [W:0] r;
  logic [W:0] x;

  always_comb begin
    if (sub) r = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
    else     r = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    x   = {1'b0, a} ^ {1'b0, b} ^ r;
    res = r[W-1:0];
    c   = r[W];
    h   = x[HB];
    v   = x[W-1] ^ r[W];
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int W = 8
) (
  input  logic [W-1:0]          a,
  input  logic                  cin,
  input  acc_alu_pkg::alu_op_e  op,
  output logic [W-1:0]          res,
  output logic                  cout
);
  import acc_alu_pkg::*;

  always_comb begin
    res  = a;
    cout = a[0];
    case (op)
      OP_ASR: begin res = {a[W-1], a[W-1:1]}; cout = a[0];   end
      OP_LSR: begin res = {1'b0,   a[W-1:1]}; cout = a[0];   end
      OP_LSL: begin res = {a[W-2:0], 1'b0};   cout = a[W-1]; end
      OP_ROL: begin res = {a[W-2:0], cin};    cout = a[W-1]; end
      OP_ROR: begin res = {cin, a[W-1:1]};    cout = a[0];   end
      default: begin res = a; cout = a[0]; end
    endcase
  end
endmodule

// File: rtl/alu_unary.sv
module alu_unary #(
  parameter int W = 8
) (
  input  logic [W-1:0]          a,
  input  acc_alu_pkg::alu_op_e  op,
  output logic [W-1:0]          res,
  output logic                  v
);
  import acc_alu_pkg::*;
  localparam int HB = W / 2;
  localparam logic [W-1:0] MSB_ONLY = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAX_POS  = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    res = a;
    v   = 1'b0;
    case (op)
      OP_INC:  begin res = a + ONE; v = (res == MSB_ONLY); end
      OP_DEC:  begin res = a - ONE; v = (res == MAX_POS);  end
      OP_COM:  res = ~a;
      OP_NEG:  begin res = ~a + ONE; v = (a == MSB_ONLY); end
      OP_CLR:  res = '0;
      OP_SWAP: res = {a[HB-1:0], a[W-1:HB]};
      default: res = a;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int W  = acc_alu_pkg::DW,
  parameter int FW = acc_alu_pkg::FW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [4:0]    op_i,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic [FW-1:0] flags_i,
  output logic [W-1:0]  res_o,
  output logic          wr_o,
  output logic [FW-1:0] flags_o
);
  import acc_alu_pkg::*;

  alu_op_e       op;
  logic [W-1:0]  as_res, sh_res, un_res, val;
  logic          as_c, as_h, as_v, sh_c, un_v;
  logic          as_sub, as_cin, wr, nz_upd;
  logic [FW-1:0] f;

  assign op     = alu_op_e'(op_i);
  assign as_sub = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
  assign as_cin = ((op == OP_ADC) || (op == OP_SBC)) && flags_i[FL_C];

  alu_addsub #(.W(W)) u_addsub (
    .a(a_i), .b(b_i), .cin(as_cin), .sub(as_sub),
    .res(as_res), .c(as_c), .h(as_h), .v(as_v)
  );

  alu_shift #(.W(W)) u_shift (
    .a(a_i), .cin(flags_i[FL_C]), .op(op), .res(sh_res), .cout(sh_c)
  );

  alu_unary #(.W(W)) u_unary (
    .a(a_i), .op(op), .res(un_res), .v(un_v)
  );

  always_comb begin
    val    = a_i;
    wr     = 1'b0;
    f      = flags_i;
    nz_upd = 1'b1;
    case (op)
      OP_ADD, OP_ADC: begin
        val = as_res; wr = 1'b1;
        f[FL_C] = as_c; f[FL_H] = as_h; f[FL_V] = as_v;
      end
      OP_SUB, OP_SBC: begin
        val = as_res; wr = 1'b1;
        f[FL_C] = as_c; f[FL_V] = as_v;
      end
      OP_CMP: begin
        val = as_res;
        f[FL_C] = as_c; f[FL_V] = as_v;
      end
      OP_AND:  begin val = a_i & b_i; wr = 1'b1; f[FL_V] = 1'b0; end
      OP_OR:   begin val = a_i | b_i; wr = 1'b1; f[FL_V] = 1'b0; end
      OP_XOR:  begin val = a_i ^ b_i; wr = 1'b1; f[FL_V] = 1'b0; end
      OP_BIT:  begin val = a_i & b_i;            f[FL_V] = 1'b0; end
      OP_PASS: begin val = b_i;       wr = 1'b1; f[FL_V] = 1'b0; end
      OP_ASR, OP_LSR, OP_LSL, OP_ROL, OP_ROR: begin
        val = sh_res; wr = 1'b1;
        f[FL_C] = sh_c;
        f[FL_V] = sh_c ^ sh_res[W-1];
      end
      OP_INC, OP_DEC: begin val = un_res; wr = 1'b1; f[FL_V] = un_v; end
      OP_COM: begin
        val = un_res; wr = 1'b1; f[FL_C] = 1'b1; f[FL_V] = 1'b0;
      end
      OP_NEG: begin
        val = un_res; wr = 1'b1; f[FL_V] = un_v; f[FL_C] = |a_i;
      end
      OP_CLR:  begin val = un_res; wr = 1'b1; f[FL_V] = 1'b0; end
      OP_SWAP: begin val = un_res; wr = 1'b1; nz_upd = 1'b0; end
      default: nz_upd = 1'b0;
    endcase
    if (nz_upd) begin
      f[FL_N] = val[W-1];
      f[FL_Z] = (val == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o   <= '0;
      wr_o    <= 1'b0;
      flags_o <= '0;
    end else begin
      res_o   <= wr ? val : a_i;
      wr_o    <= wr;
      flags_o <= f;
    end
  end

  // Marks that the previous edge loaded real data rather than reset values.
  logic live_q;
  always_ff @(posedge clk) begin
    if (rst) live_q <= 1'b0;
    else     live_q <= 1'b1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (res_o == '0 && !wr_o && flags_o == '0));

  assert_cmp_bit_nowrite_R4: assert property (@(posedge clk) disable iff (rst)
    (live_q && ($past(op_i) == OP_CMP || $past(op_i) == OP_BIT))
      |-> (!wr_o && res_o == $past(a_i)));

  assert_shift_v_rule_R6: assert property (@(posedge clk) disable iff (rst)
    (live_q && $past(op_i) >= OP_ASR && $past(op_i) <= OP_ROR)
      |-> (flags_o[FL_V] == (flags_o[FL_N] ^ flags_o[FL_C])));

  assert_incdec_keep_c_R8: assert property (@(posedge clk) disable iff (rst)
    (live_q && ($past(op_i) == OP_INC || $past(op_i) == OP_DEC))
      |-> (flags_o[FL_C] == $past(flags_i[FL_C])));

  assert_com_flags_R9: assert property (@(posedge clk) disable iff (rst)
    (live_q && $past(op_i) == OP_COM) |-> (flags_o[FL_C] && !flags_o[FL_V]));

  assert_clr_state_R10: assert property (@(posedge clk) disable iff (rst)
    (live_q && $past(op_i) == OP_CLR)
      |-> (res_o == '0 && flags_o[FL_Z] && !flags_o[FL_N] && !flags_o[FL_V]));

  assert_swap_flags_R11: assert property (@(posedge clk) disable iff (rst)
    (live_q && $past(op_i) == OP_SWAP) |-> (flags_o == $past(flags_i)));

  assert_unused_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (live_q && $past(op_i) > OP_SWAP)
      |-> (!wr_o && res_o == $past(a_i) && flags_o == $past(flags_i)));
endmodule

// File: tb/test_acc_alu.sv
module test_acc_alu;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] op_i = '0;
  logic [7:0] a_i = '0, b_i = '0;
  logic [4:0] flags_i = '0;
  logic [7:0] res_o;
  logic       wr_o;
  logic [4:0] flags_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_alu i_acc_alu (
    .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .flags_i(flags_i), .res_o(res_o), .wr_o(wr_o), .flags_o(flags_o)
  );

  // Expected {wr, result[7:0], flags[4:0]}; flags = {V,H,N,Z,C}
  function automatic logic [13:0] model(logic [4:0] op, logic [7:0] a,
                                        logic [7:0] b, logic [4:0] fi);
    logic [8:0] s;
    logic [7:0] r;
    logic       w, nz, cin;
    logic [4:0] fo;
    r = a; w = 1'b0; fo = fi; nz = 1'b1; cin = fi[0];
    case (op)
      5'd0, 5'd1: begin
        s = 9'(a) + 9'(b) + ((op == 5'd1) ? 9'(cin) : 9'd0);
        r = s[7:0]; w = 1'b1; fo[0] = s[8];
        fo[3] = s[4] ^ a[4] ^ b[4];
        fo[4] = a[7] ^ b[7] ^ s[7] ^ s[8];
      end
      5'd2, 5'd3, 5'd4: begin
        s = 9'(a) - 9'(b) - ((op == 5'd3) ? 9'(cin) : 9'd0);
        r = s[7:0]; w = (op != 5'd4); fo[0] = s[8];
        fo[4] = a[7] ^ b[7] ^ s[7] ^ s[8];
      end
      5'd5: begin r = a & b; w = 1'b1; fo[4] = 1'b0; end
      5'd6: begin r = a | b; w = 1'b1; fo[4] = 1'b0; end
      5'd7: begin r = a ^ b; w = 1'b1; fo[4] = 1'b0; end
      5'd8: begin r = a & b;           fo[4] = 1'b0; end
      5'd9: begin r = b;     w = 1'b1; fo[4] = 1'b0; end
      5'd10: begin r = {a[7], a[7:1]}; fo[0] = a[0]; w = 1'b1; end
      5'd11: begin r = {1'b0, a[7:1]}; fo[0] = a[0]; w = 1'b1; end
      5'd12: begin r = {a[6:0], 1'b0}; fo[0] = a[7]; w = 1'b1; end
      5'd13: begin r = {a[6:0], cin};  fo[0] = a[7]; w = 1'b1; end
      5'd14: begin r = {cin, a[7:1]};  fo[0] = a[0]; w = 1'b1; end
      5'd15: begin r = a + 8'd1; w = 1'b1; fo[4] = (r == 8'h80); end
      5'd16: begin r = a - 8'd1; w = 1'b1; fo[4] = (r == 8'h7F); end
      5'd17: begin r = ~a; w = 1'b1; fo[0] = 1'b1; fo[4] = 1'b0; end
      5'd18: begin
        r = 8'd0 - a; w = 1'b1; fo[4] = (a == 8'h80); fo[0] = (a != 8'h00);
      end
      5'd19: begin r = 8'h00; w = 1'b1; fo[4] = 1'b0; end
      5'd20: begin r = {a[3:0], a[7:4]}; w = 1'b1; nz = 1'b0; end
      default: nz = 1'b0;
    endcase
    if (nz) begin fo[2] = r[7]; fo[1] = (r == 8'h00); end
    if (op >= 5'd10 && op <= 5'd14) fo[4] = fo[0] ^ fo[2];
    if (!w) r = a;
    return {w, r, fo};
  endfunction

  function automatic string tag_of(logic [4:0] op);
    if (op <= 5'd1)  return "R3";
    if (op <= 5'd4)  return "R4";
    if (op <= 5'd9)  return "R5";
    if (op <= 5'd11) return "R6";
    if (op <= 5'd14) return "R7";
    if (op <= 5'd16) return "R8";
    if (op <= 5'd18) return "R9";
    if (op == 5'd19) return "R10";
    if (op == 5'd20) return "R11";
    return "R12";
  endfunction

  // Called at a falling edge; drives, waits one full cycle, checks (R2, R13).
  task automatic run(logic [4:0] op, logic [7:0] a, logic [7:0] b, logic [4:0] f);
    logic [13:0] exp;
    op_i = op; a_i = a; b_i = b; flags_i = f;
    exp = model(op, a, b, f);
    @(negedge clk);
    n_tests++;
    if ({wr_o, res_o, flags_o} !== exp) begin
      n_fail++;
      $display("FAIL %s/R2/R13 op=%0d a=%h b=%h f=%b: got wr=%b res=%h fl=%b, exp wr=%b res=%h fl=%b",
               tag_of(op), op, a, b, f, wr_o, res_o, flags_o,
               exp[13], exp[12:5], exp[4:0]);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    n_tests++;
    if (res_o !== 8'h00 || wr_o !== 1'b0 || flags_o !== 5'b0) begin
      n_fail++;
      $display("FAIL R1 reset: got res=%h wr=%b fl=%b, exp res=00 wr=0 fl=00000",
               res_o, wr_o, flags_o);
    end
    rst = 1'b0;

    // Directed corners
    run(5'd0,  8'h7F, 8'h01, 5'b00000); // R3 signed overflow + half carry
    run(5'd0,  8'hFF, 8'h01, 5'b00000); // R3 carry out, zero
    run(5'd1,  8'h80, 8'h80, 5'b00001); // R3 adc with carry in
    run(5'd2,  8'h00, 8'h01, 5'b01000); // R4 borrow, H kept
    run(5'd3,  8'h80, 8'h00, 5'b00001); // R4 sbc overflow
    run(5'd4,  8'h42, 8'h42, 5'b10001); // R4 compare equal, no write
    run(5'd8,  8'hF0, 8'h0F, 5'b10000); // R5 bit test zero, no write
    run(5'd9,  8'h00, 8'h9C, 5'b10101); // R5 pass-through
    run(5'd10, 8'h81, 8'h00, 5'b00000); // R6 asr
    run(5'd11, 8'h01, 8'h00, 5'b00000); // R6 lsr to zero
    run(5'd13, 8'h80, 8'h00, 5'b00000); // R7 rol carry out
    run(5'd14, 8'h01, 8'h00, 5'b00001); // R7 ror carry in
    run(5'd15, 8'h7F, 8'h00, 5'b00001); // R8 inc wrap
    run(5'd16, 8'h80, 8'h00, 5'b00000); // R8 dec wrap
    run(5'd17, 8'h00, 8'h00, 5'b10000); // R9 com
    run(5'd18, 8'h80, 8'h00, 5'b00000); // R9 neg of 0x80
    run(5'd18, 8'h00, 8'h00, 5'b00001); // R9 neg of zero
    run(5'd19, 8'h5A, 8'h00, 5'b11101); // R10 clear
    run(5'd20, 8'hA5, 8'h00, 5'b10110); // R11 swap keeps flags
    run(5'd31, 8'h33, 8'h44, 5'b01011); // R12 unused code

    // Constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] op;
      if ($urandom_range(0, 7) == 0) op = 5'(21 + $urandom_range(0, 10));
      else                           op = 5'($urandom_range(0, 20));
      run(op, 8'($urandom), 8'($urandom), 5'($urandom));
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL R2 watchdog: got no completion, exp finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule